// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. After reset it takes sole ownership of the command bus: clock enable, the four command strobes, the bank address and the row address. It walks the memory through its mandatory bring-up and mode-programming sequence, and when it has finished it raises a ready level that hands the bus to the normal-traffic controller.

Every wait is a parameter. The power-on hold, the quiet time after clock enable rises, the precharge period and the refresh cycle time are given in nanoseconds. Each is turned into a cycle count at elaboration as the ceiling of time over the clock period, with a floor of one cycle. The mode-register settle time and the minimum distance from the DLL reset to the driver-impedance step are given directly in cycles. The four register payloads are parameters too. The sequencer forces only the bits that each step is defined by, and it passes the other fields through unchanged.

Commands use the strobe code {cs_n, ras_n, cas_n, we_n}: 0111 is no-operation, 0010 is precharge, 0001 is auto-refresh and 0000 is a mode-register write. For a mode-register write, the bank address picks the target: 00 is the main register, 01 is extended register 1, 10 is extended register 2 and 11 is extended register 3.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: From reset, cke and odt are low and the bus carries no-operation (0111) for ceil(T_PWR_NS*1000/CLK_PS) cycles, counting the cycle in which reset is released.
- R2: cke then rises and stays high. No-operation follows for ceil(T_CKE_NS*1000/CLK_PS) cycles, then one precharge-all (0010 with addr[10]=1, bank 0, all other address bits 0).
- R3: Four mode-register writes (0000) follow in this order. First, bank 10 with the EMR2 payload. Second, bank 11 with the EMR3 payload. Third, DLL enable: bank 01 with the EMR1 payload, with addr[0]=0, addr[13]=0 and addr[9:7]=000. Fourth, DLL reset: bank 00 with the MR payload, with addr[8]=1 and addr[13]=0.
- R4: After the DLL reset the bus carries one precharge-all, then N_REF auto-refresh commands (0001, bank and address 0), then a bank-00 write with the MR payload, with addr[8]=0 and addr[13]=0.
- R5: Two bank-01 writes then set the driver step. Both carry the EMR1 payload with addr[0]=0 and addr[13]=0. The first has addr[9:7]=111 and the second has addr[9:7]=000.
- R6: Each precharge-all is followed by exactly ceil(T_RP_NS*1000/CLK_PS) no-operation cycles. Each auto-refresh is followed by exactly ceil(T_RFC_NS*1000/CLK_PS) cycles. Each mode-register write is followed by exactly T_MRD_CYC cycles, except where R7 lengthens the wait.
- R7: The first driver-step write (addr[9:7]=111) is issued no fewer than DLL_GAP_CYC cycles after the DLL-reset write. If the waits between them add up to less, it comes exactly DLL_GAP_CYC cycles after.
- R8: init_done stays low until the settle wait after the final driver-step write has elapsed. It then stays high, with cke high and no-operation on the bus, until the next reset.
- R9: odt is low in every cycle, and each cycle carries at most one command.
- R10: A reset asserted at any point, including after init_done has risen, returns the block at once to the state of R1, and the sequence starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address / register select |
| addr | output | ROW_W | Row address / register payload |
| odt | output | 1 | On-die termination enable, held low |
| init_done | output | 1 | Sequence complete; bus may be handed over |

## Verification
Two things can end the wait after the operating-mode write: the settle-time counter running out, and the DLL-to-driver distance being met. Both decide the same transition, so the later of the two must win. The default timing makes the distance the longer one, so the settle counter sits at zero while the gate still holds the sequence. The reference model builds the expected bus for every cycle from the requirements alone, and pads no-operations until exactly DLL_GAP_CYC cycles separate the two writes. The bus is compared every clock, so an early or late driver write, or one missing padding cycle, shows up as a mismatch at a known cycle. A separate checker keeps its own distance counter for the same rule.

// File: rtl/ddr2_bringup_pkg.sv
package ddr2_bringup_pkg;

   typedef enum logic [3:0] {
      ST_PWR,
      ST_CKE,
      ST_PALL_A,
      ST_EMR2,
      ST_EMR3,
      ST_DLL_EN,
      ST_DLL_RST,
      ST_PALL_B,
      ST_REFR,
      ST_MR_OPER,
      ST_OCD_DFLT,
      ST_OCD_EXIT,
      ST_READY
   } step_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_t;

   localparam cmd_t CMD_NOP = 4'b0111;
   localparam cmd_t CMD_PRE = 4'b0010;
   localparam cmd_t CMD_REF = 4'b0001;
   localparam cmd_t CMD_MRS = 4'b0000;

   // ceiling(time / period) with a floor of one cycle
   function automatic int unsigned ns_to_cycles(input longint unsigned t_ns,
                                                input longint unsigned clk_ps);
      longint unsigned c;
      c = (t_ns * 64'd1000 + clk_ps - 64'd1) / clk_ps;
      if (c < 64'd1) c = 64'd1;
      return int'(c);
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= CNT_W'(RST_VAL);
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr2_gap_meter.sv
module ddr2_gap_meter #(
   parameter int unsigned LIMIT = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic reached
);
   localparam int unsigned GW  = $clog2(LIMIT + 1);
   localparam int unsigned TOP = (LIMIT > 0) ? LIMIT - 1 : 0;

   logic [GW-1:0] cnt_q;

   // value k in the k-th cycle after the clearing command
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clear)             cnt_q <= GW'(1);
      else if (cnt_q < GW'(TOP))  cnt_q <= cnt_q + GW'(1);
   end

   assign reached = (cnt_q >= GW'(TOP));
endmodule

// File: rtl/ddr2_cmd_encoder.sv
module ddr2_cmd_encoder
   import ddr2_bringup_pkg::*;
#(
   parameter int unsigned ROW_W = 14,
   parameter int unsigned BA_W  = 2,
   parameter logic [ROW_W-1:0] MR_VAL   = '0,
   parameter logic [ROW_W-1:0] EMR1_VAL = '0,
   parameter logic [ROW_W-1:0] EMR2_VAL = '0,
   parameter logic [ROW_W-1:0] EMR3_VAL = '0
) (
   input  step_e            step,
   input  logic             issue,
   output cmd_t             cmd,
   output logic [BA_W-1:0]  ba,
   output logic [ROW_W-1:0] addr
);
   localparam logic [ROW_W-1:0] M_A0  = ROW_W'(1);
   localparam logic [ROW_W-1:0] M_A8  = ROW_W'(1) << 8;
   localparam logic [ROW_W-1:0] M_A10 = ROW_W'(1) << 10;
   localparam logic [ROW_W-1:0] M_OCD = ROW_W'(7) << 7;

   logic [ROW_W-1:0] m_a13;

   generate
      if (ROW_W > 13) begin : g_a13
         assign m_a13 = ROW_W'(1) << 13;
      end else begin : g_no_a13
         assign m_a13 = '0;
      end
   endgenerate

   logic [ROW_W-1:0] emr1_base, mr_base;
   assign emr1_base = EMR1_VAL & ~(M_A0 | M_OCD | m_a13);
   assign mr_base   = MR_VAL & ~(M_A8 | m_a13);

   always_comb begin
      cmd  = CMD_NOP;
      ba   = '0;
      addr = '0;
      if (issue) begin
         unique case (step)
            ST_PALL_A, ST_PALL_B: begin
               cmd  = CMD_PRE;
               addr = M_A10;
            end
            ST_EMR2: begin
               cmd  = CMD_MRS;
               ba   = BA_W'(2);
               addr = EMR2_VAL;
            end
            ST_EMR3: begin
               cmd  = CMD_MRS;
               ba   = BA_W'(3);
               addr = EMR3_VAL;
            end
            ST_DLL_EN, ST_OCD_EXIT: begin
               cmd  = CMD_MRS;
               ba   = BA_W'(1);
               addr = emr1_base;
            end
            ST_DLL_RST: begin
               cmd  = CMD_MRS;
               addr = mr_base | M_A8;
            end
            ST_REFR: cmd = CMD_REF;
            ST_MR_OPER: begin
               cmd  = CMD_MRS;
               addr = mr_base;
            end
            ST_OCD_DFLT: begin
               cmd  = CMD_MRS;
               ba   = BA_W'(1);
               addr = emr1_base | M_OCD;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ddr2_bringup_seq.sv
module ddr2_bringup_seq
   import ddr2_bringup_pkg::*;
#(
   parameter int unsigned CLK_PS      = 8000,
   parameter int unsigned T_PWR_NS    = 200000,
   parameter int unsigned T_CKE_NS    = 400,
   parameter int unsigned T_RP_NS     = 15,
   parameter int unsigned T_RFC_NS    = 105,
   parameter int unsigned T_MRD_CYC   = 2,
   parameter int unsigned DLL_GAP_CYC = 200,
   parameter int unsigned N_REF       = 2,
   parameter int unsigned ROW_W       = 14,
   parameter int unsigned BA_W        = 2,
   parameter logic [ROW_W-1:0] MR_VAL   = 'h0232,
   parameter logic [ROW_W-1:0] EMR1_VAL = 'h0044,
   parameter logic [ROW_W-1:0] EMR2_VAL = '0,
   parameter logic [ROW_W-1:0] EMR3_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             cke,
   output logic             cs_n,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic [BA_W-1:0]  ba,
   output logic [ROW_W-1:0] addr,
   output logic             odt,
   output logic             init_done
);
   localparam int unsigned C_PWR = ns_to_cycles(T_PWR_NS, CLK_PS);
   localparam int unsigned C_CKE = ns_to_cycles(T_CKE_NS, CLK_PS);
   localparam int unsigned C_RP  = ns_to_cycles(T_RP_NS, CLK_PS);
   localparam int unsigned C_RFC = ns_to_cycles(T_RFC_NS, CLK_PS);
   localparam int unsigned C_MRD = (T_MRD_CYC < 1) ? 1 : T_MRD_CYC;
   localparam int unsigned C_MAX = max_u(max_u(C_PWR, C_CKE), max_u(max_u(C_RP, C_RFC), C_MRD));
   localparam int unsigned CNT_W = $clog2(C_MAX + 1);
   localparam int unsigned REF_W = $clog2(N_REF + 1);

   generate
      if (ROW_W < 11) begin : g_bad_row
         $error("ROW_W must cover address bit 10");
      end
      if (BA_W < 2) begin : g_bad_ba
         $error("BA_W must be at least 2");
      end
      if (N_REF < 2) begin : g_bad_ref
         $error("N_REF must be at least 2");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
   endgenerate

   step_e            step_q;
   logic             issue_q;
   logic [REF_W-1:0] ref_q;

   logic             t_load, t_zero, gap_ok, gap_clr, hold;
   logic [CNT_W-1:0] t_val;
   int unsigned      wait_cyc;
   cmd_t             cmd;

   always_comb begin
      unique case (step_q)
         ST_PWR:               wait_cyc = C_CKE;
         ST_PALL_A, ST_PALL_B: wait_cyc = C_RP;
         ST_REFR:              wait_cyc = C_RFC;
         default:              wait_cyc = C_MRD;
      endcase
   end

   assign t_load  = issue_q || ((step_q == ST_PWR) && t_zero);
   assign t_val   = CNT_W'(wait_cyc - 1);
   assign gap_clr = issue_q && (step_q == ST_DLL_RST);
   assign hold    = (step_q == ST_MR_OPER) && !gap_ok;

   ddr2_wait_timer #(.CNT_W(CNT_W), .RST_VAL(C_PWR - 1)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
   );

   ddr2_gap_meter #(.LIMIT(DLL_GAP_CYC)) u_gap (
      .clk(clk), .rst_n(rst_n), .clear(gap_clr), .reached(gap_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= ST_PWR;
         issue_q <= 1'b0;
         ref_q   <= '0;
      end else if (step_q == ST_READY) begin
         step_q  <= ST_READY;
      end else if ((step_q == ST_PWR) || (step_q == ST_CKE)) begin
         if (t_zero) begin
            step_q  <= step_e'(step_q + 4'd1);
            issue_q <= (step_q == ST_CKE);
         end
      end else if (issue_q) begin
         issue_q <= 1'b0;
         if (step_q == ST_REFR) ref_q <= ref_q + REF_W'(1);
      end else if (t_zero && !hold) begin
         if ((step_q == ST_REFR) && (ref_q < REF_W'(N_REF))) begin
            issue_q <= 1'b1;
         end else begin
            step_q  <= step_e'(step_q + 4'd1);
            issue_q <= (step_q != ST_OCD_EXIT);
         end
      end
   end

   ddr2_cmd_encoder #(
      .ROW_W(ROW_W), .BA_W(BA_W), .MR_VAL(MR_VAL), .EMR1_VAL(EMR1_VAL),
      .EMR2_VAL(EMR2_VAL), .EMR3_VAL(EMR3_VAL)
   ) u_enc (
      .step(step_q), .issue(issue_q), .cmd(cmd), .ba(ba), .addr(addr)
   );

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign cke       = (step_q != ST_PWR);
   assign odt       = 1'b0;
   assign init_done = (step_q == ST_READY);
endmodule

// File: rtl/ddr2_bringup_chk.sv
module ddr2_bringup_chk #(
   parameter int unsigned ROW_W   = 14,
   parameter int unsigned BA_W    = 2,
   parameter int unsigned DLL_GAP = 200
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cke,
   input logic             cs_n,
   input logic             ras_n,
   input logic             cas_n,
   input logic             we_n,
   input logic [BA_W-1:0]  ba,
   input logic [ROW_W-1:0] addr,
   input logic             odt,
   input logic             init_done
);
   logic is_nop, is_pre, is_mrs, dll_rst, ocd_dflt;
   assign is_nop   = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
   assign is_pre   = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
   assign is_mrs   = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);
   assign dll_rst  = is_mrs && (ba == BA_W'(0)) && addr[8];
   assign ocd_dflt = is_mrs && (ba == BA_W'(1)) && (addr[9:7] == 3'b111);

   int unsigned since_q;
   logic        seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= 0;
         seen_q  <= 1'b0;
      end else if (dll_rst) begin
         since_q <= 1;
         seen_q  <= 1'b1;
      end else if (since_q < DLL_GAP) begin
         since_q <= since_q + 1;
      end
   end

   p_cke_low_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> is_nop);
   p_cke_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);
   p_pall_a10_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> addr[10]);
   p_cmd_then_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !is_nop |=> is_nop);
   p_ocd_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ocd_dflt |-> (seen_q && (since_q >= DLL_GAP)));
   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);
   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (is_nop && cke));
   p_odt_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> !odt);
endmodule

bind ddr2_bringup_seq ddr2_bringup_chk #(
   .ROW_W(ROW_W), .BA_W(BA_W), .DLL_GAP(DLL_GAP_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
   .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .odt(odt),
   .init_done(init_done)
);

// File: tb/sim_ddr2_bringup_seq.sv
`timescale 1ns/1ps
module sim_ddr2_bringup_seq;
   localparam int CLK_PS = 8000;
   localparam int ROW_W  = 14;
   localparam int BA_W   = 2;
   localparam int N_REF  = 3;
   localparam int GAP    = 200;
   localparam int MRD    = 2;
   localparam logic [ROW_W-1:0] MRV  = 14'h2B52;
   localparam logic [ROW_W-1:0] E1V  = 14'h23C7;
   localparam logic [ROW_W-1:0] E2V  = 14'h0080;
   localparam logic [ROW_W-1:0] E3V  = 14'h0003;
   localparam int EW = 7 + BA_W + ROW_W;

   function automatic int ceil_cyc(input longint ns);
      longint c;
      c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
      return (c < 1) ? 1 : int'(c);
   endfunction

   localparam int W_PWR = 200000 * 1000 / CLK_PS;
   localparam int W_CKE = 50;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cke, cs_n, ras_n, cas_n, we_n, odt, init_done;
   logic [BA_W-1:0]  ba;
   logic [ROW_W-1:0] addr;

   always #4 clk = ~clk;

   ddr2_bringup_seq #(
      .CLK_PS(CLK_PS), .T_PWR_NS(200000), .T_CKE_NS(400), .T_RP_NS(15),
      .T_RFC_NS(105), .T_MRD_CYC(MRD), .DLL_GAP_CYC(GAP), .N_REF(N_REF),
      .ROW_W(ROW_W), .BA_W(BA_W), .MR_VAL(MRV), .EMR1_VAL(E1V),
      .EMR2_VAL(E2V), .EMR3_VAL(E3V)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .odt(odt),
      .init_done(init_done)
   );

   int n_cmp = 0, n_bad = 0, cyc_no = 0;
   logic [EW-1:0] exp_q[$];
   string         tag_q[$];

   // word: {done, cke, odt, cs,ras,cas,we, ba, addr}
   function automatic logic [EW-1:0] mk(input bit done, input bit ck, input bit [3:0] c,
                                        input int b, input logic [ROW_W-1:0] a);
      return {done, ck, 1'b0, c, BA_W'(b), a};
   endfunction

   function automatic void push(input logic [EW-1:0] w, input string t);
      exp_q.push_back(w);
      tag_q.push_back(t);
   endfunction

   function automatic void nops(input int n, input string t);
      for (int i = 0; i < n; i++) push(mk(0, 1, 4'b0111, 0, '0), t);
   endfunction

   function automatic void build();
      logic [ROW_W-1:0] e1b, mrb;
      int i0;
      int t_rp, t_rfc;
      t_rp  = ceil_cyc(15);
      t_rfc = ceil_cyc(105);
      e1b = E1V & ~14'h2381;  // clear A13, A9..A7, A0
      mrb = MRV & ~14'h2100;  // clear A13, A8
      for (int i = 0; i < ceil_cyc(200000); i++) push(mk(0, 0, 4'b0111, 0, '0), "R1");
      for (int i = 0; i < ceil_cyc(400); i++) push(mk(0, 1, 4'b0111, 0, '0), "R2");
      push(mk(0, 1, 4'b0010, 0, 14'h0400), "R2");       nops(t_rp, "R6");
      push(mk(0, 1, 4'b0000, 2, E2V), "R3");            nops(MRD, "R6");
      push(mk(0, 1, 4'b0000, 3, E3V), "R3");            nops(MRD, "R6");
      push(mk(0, 1, 4'b0000, 1, e1b), "R3");            nops(MRD, "R6");
      i0 = exp_q.size();
      push(mk(0, 1, 4'b0000, 0, mrb | 14'h0100), "R3"); nops(MRD, "R6");
      push(mk(0, 1, 4'b0010, 0, 14'h0400), "R4");       nops(t_rp, "R6");
      for (int r = 0; r < N_REF; r++) begin
         push(mk(0, 1, 4'b0001, 0, '0), "R4");          nops(t_rfc, "R6");
      end
      push(mk(0, 1, 4'b0000, 0, mrb), "R4");            nops(MRD, "R6");
      while (exp_q.size() - i0 < GAP) push(mk(0, 1, 4'b0111, 0, '0), "R7");
      push(mk(0, 1, 4'b0000, 1, e1b | 14'h0380), "R5"); nops(MRD, "R6");
      push(mk(0, 1, 4'b0000, 1, e1b), "R5");            nops(MRD, "R8");
   endfunction

   task automatic check(input string t, input logic [EW-1:0] e);
      logic [EW-1:0] act;
      act = {init_done, cke, odt, cs_n, ras_n, cas_n, we_n, ba, addr};
      n_cmp++;
      if (act !== e) begin
         n_bad++;
         $display("FAIL %s cycle %0d: got %h expected %h", t, cyc_no, act, e);
      end
   endtask

   task automatic run_stream(input int limit);
      for (int i = 0; i < limit && i < exp_q.size(); i++) begin
         if (i > 0) @(negedge clk);
         #1 cyc_no = i;
         check(tag_q[i], exp_q[i]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog: got no finish expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      build();
      if (W_PWR != ceil_cyc(200000) || W_CKE != ceil_cyc(400)) $display("note: timing table differs");
      repeat (4) @(negedge clk);
      #1 check("R1", mk(0, 0, 4'b0111, 0, '0));  // reset state
      @(negedge clk);
      rst_n = 1'b1;
      run_stream(exp_q.size());
      for (int i = 0; i < 40; i++) begin       // R8: done persists, bus quiet
         @(negedge clk);
         #1 cyc_no++;
         check("R8", mk(1, 1, 4'b0111, 0, '0));
      end
      @(negedge clk);
      rst_n = 1'b0;                              // R10: reset after done
      #1 check("R10", mk(0, 0, 4'b0111, 0, '0));
      repeat (3) @(negedge clk);
      #1 check("R10", mk(0, 0, 4'b0111, 0, '0));
      @(negedge clk);
      rst_n = 1'b1;
      run_stream(60);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule